// File: doc/BRIEF.md
# Flash Byte-Programming Sequencer

This block models the parallel programming port of a small on-chip program memory. An external programmer presents an address, a data byte and a three-bit command. It then pulses an active-low program strobe. The sequencer turns each strobe into a self-timed operation:

- a byte write, or the programming of one of three lock bits, which lasts `WRITE_CYC` clock cycles;
- a full-chip erase, which needs the strobe held low for `ERASE_CYC` cycles.

While an operation runs, a ready output stays low. A verify read of the byte being written returns its top bit inverted, so the programmer can poll for completion. Signature reads return fixed identification bytes that sit outside the array. Lock bits 1 and 2 each mask verify reads.

The controller has three states:

- **IDLE**: ready is high.
- **PROG**: a timed byte or lock-bit write is in progress.
- **ERASE**: a timed hold of the strobe is in progress.

The transitions are:

- IDLE→PROG on a strobe fall with a write or lock command.
- IDLE→ERASE on a strobe fall with the erase command.
- PROG→IDLE when the timer expires. The write is committed at that point.
- ERASE→IDLE, by one of two routes:
  - when the timer expires with the strobe still low, which erases the array;
  - when the strobe rises early, which aborts the erase and changes nothing.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset and after a completed chip erase, every array byte reads FFh through a verify read (command 010).
- R2: A strobe fall with command 001 latches the address and data. After `WRITE_CYC` cycles the byte becomes (old AND data), so bits can only go from 1 to 0.
- R3: Ready is high in IDLE. It is low from the clock edge that accepts a write, lock or erase command. It returns high exactly `WRITE_CYC` cycles later for a write or lock, and `ERASE_CYC` cycles later for an erase.
- R4: While a byte write is pending, a verify read of that same address returns bit 7 as the inverse of the data bit 7 being written. Once ready is high again, the read returns the stored result.
- R5: Command 011 with the strobe held low for `ERASE_CYC` cycles sets every byte to FFh and clears all three lock bits. If the strobe rises earlier, the erase is abandoned: the array and the lock bits are unchanged and ready goes high on the next edge.
- R6: Signature reads (command 100) return 1Eh at address 30h and 52h at 31h. At 32h they return FFh when `HIGH_VOLT` = 1 and 05h when it is 0. At any other address they return 00h.
- R7: Commands 101, 110 and 111 set lock bit 1, 2 and 3 respectively after a `WRITE_CYC` busy period. A set lock bit is cleared only by a completed erase.
- R8: While lock bit 1 or lock bit 2 is set, verify reads return FFh. Lock bit 3 alone does not alter verify data.
- R9: A strobe fall received while ready is low is ignored. It neither modifies the array nor lengthens the busy period.
- R10: In commands other than 010 and 100, the data output is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address, also used to select a signature byte |
| din | input | 8 | Data to program |
| cmd | input | 3 | Command select |
| prog_n | input | 1 | Active-low program strobe |
| dout | output | 8 | Verify, polling or signature data |
| ready | output | 1 | High when idle, low while busy |

## Verification
The properties assume that `prog_n` and `cmd` change only between clock edges. They also assume that one strobe fall marks one command, so a command and its strobe are presented together. The bench drives every input on the falling clock edge and keeps a command stable until the strobe has been sampled. It changes `cmd` and `addr` during busy periods only to poll or to issue deliberately ignored strobes. The sweeps cover all 64 addresses with two overlapping data patterns. Expected bytes are derived by AND-ing the patterns.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [2:0] {
        CMD_NONE   = 3'b000,
        CMD_WRITE  = 3'b001,
        CMD_VERIFY = 3'b010,
        CMD_ERASE  = 3'b011,
        CMD_SIG    = 3'b100,
        CMD_LOCK1  = 3'b101,
        CMD_LOCK2  = 3'b110,
        CMD_LOCK3  = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } state_e;

    localparam logic [7:0] SIG_MAKER = 8'h1E;
    localparam logic [7:0] SIG_MODEL = 8'h52;
    localparam logic [7:0] SIG_HV    = 8'hFF;
    localparam logic [7:0] SIG_LV    = 8'h05;
endpackage

// File: rtl/fps_strobe.sv
module fps_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    output logic fall,
    output logic held
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prog_n;
    end

    assign fall = prev_q & ~prog_n;
    assign held = ~prog_n;
endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fps_array.sv
module fps_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        lock_set,
    input  logic              erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [2:0]        locks
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     locks <= 3'b000;
        else if (erase) locks <= 3'b000;
        else            locks <= locks | lock_set;
    end

    assign rd_data = mem[rd_addr];

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !erase |=> ((locks & $past(locks)) == $past(locks)));

    assert_erase_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (locks == 3'b000));
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int CW        = 6,
    parameter int WRITE_CYC = 12,
    parameter int ERASE_CYC = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              held,
    input  logic [2:0]        cmd_raw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              done,
    output logic              load,
    output logic [CW-1:0]     load_val,
    output logic              commit_byte,
    output logic [2:0]        lock_set,
    output logic              erase_go,
    output logic              write_busy,
    output logic [ADDR_W-1:0] wa,
    output logic [7:0]        wd,
    output logic              ready
);
    state_e state, next;
    cmd_e   cmd, cmd_q;
    logic   is_prog, is_erase;

    assign cmd      = cmd_e'(cmd_raw);
    assign is_prog  = (cmd == CMD_WRITE) || (cmd == CMD_LOCK1) ||
                      (cmd == CMD_LOCK2) || (cmd == CMD_LOCK3);
    assign is_erase = (cmd == CMD_ERASE);

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE: begin
                if (fall && is_prog)       next = ST_PROG;
                else if (fall && is_erase) next = ST_ERASE;
            end
            ST_PROG:  if (done) next = ST_IDLE;
            ST_ERASE: if (!held || done) next = ST_IDLE;
            default:  next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_NONE;
            wa    <= '0;
            wd    <= 8'hFF;
        end else if (load) begin
            cmd_q <= cmd;
            wa    <= addr;
            wd    <= din;
        end
    end

    always_comb begin
        load        = (state == ST_IDLE) && fall && (is_prog || is_erase);
        load_val    = is_erase ? CW'(ERASE_CYC - 1) : CW'(WRITE_CYC - 1);
        commit_byte = (state == ST_PROG) && done && (cmd_q == CMD_WRITE);
        lock_set    = 3'b000;
        if ((state == ST_PROG) && done) begin
            if (cmd_q == CMD_LOCK1) lock_set = 3'b001;
            if (cmd_q == CMD_LOCK2) lock_set = 3'b010;
            if (cmd_q == CMD_LOCK3) lock_set = 3'b100;
        end
        erase_go   = (state == ST_ERASE) && held && done;
        write_busy = (state == ST_PROG) && (cmd_q == CMD_WRITE);
        ready      = (state == ST_IDLE);
    end

    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fall && (is_prog || is_erase)) |=> !ready);

    assert_prog_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !done) |=> (state == ST_PROG));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && fall) |=> ($stable(wa) && $stable(wd)));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int WRITE_CYC = 12,
    parameter int ERASE_CYC = 30,
    parameter bit HIGH_VOLT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [2:0]        cmd,
    input  logic              prog_n,
    output logic [7:0]        dout,
    output logic              ready
);
    localparam int MAXC = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [7:0] SIG_VOLT = HIGH_VOLT ? SIG_HV : SIG_LV;

    logic              fall, held, done, load;
    logic [CW-1:0]     load_val;
    logic              commit_byte, erase_go, write_busy;
    logic [2:0]        lock_set, locks;
    logic [ADDR_W-1:0] wa;
    logic [7:0]        wd, rd_data;

    fps_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .fall(fall), .held(held)
    );

    fps_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
    );

    fps_ctrl #(
        .ADDR_W(ADDR_W), .CW(CW), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fall(fall), .held(held), .cmd_raw(cmd),
        .addr(addr), .din(din), .done(done), .load(load), .load_val(load_val),
        .commit_byte(commit_byte), .lock_set(lock_set), .erase_go(erase_go),
        .write_busy(write_busy), .wa(wa), .wd(wd), .ready(ready)
    );

    fps_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(commit_byte), .wr_addr(wa),
        .wr_data(wd), .lock_set(lock_set), .erase(erase_go),
        .rd_addr(addr), .rd_data(rd_data), .locks(locks)
    );

    always_comb begin
        dout = 8'h00;
        if (cmd == CMD_VERIFY) begin
            if (locks[0] || locks[1])            dout = 8'hFF;
            else if (write_busy && (addr == wa)) dout = {~wd[7], rd_data[6:0]};
            else                                 dout = rd_data;
        end else if (cmd == CMD_SIG) begin
            if (addr == ADDR_W'(8'h30))      dout = SIG_MAKER;
            else if (addr == ADDR_W'(8'h31)) dout = SIG_MODEL;
            else if (addr == ADDR_W'(8'h32)) dout = SIG_VOLT;
        end
    end
endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
    localparam int AW = 6;
    localparam int N  = 1 << AW;
    localparam int W  = 12;
    localparam int E  = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [2:0]    cmd = 3'b000;
    logic          prog_n = 1'b1;
    logic [7:0]    dout;
    logic          ready;

    int vectors = 0;
    int misses  = 0;
    logic [7:0] model [N];

    flash_prog_seq #(.ADDR_W(AW), .WRITE_CYC(W), .ERASE_CYC(E), .HIGH_VOLT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .cmd(cmd),
        .prog_n(prog_n), .dout(dout), .ready(ready)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a * 29 + 8'h3C) ^ 8'h81);
    endfunction
    function automatic logic [7:0] pat_b(input int a);
        return 8'(~(a * 7)) | 8'h10;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] c, input int a, input logic [7:0] d, output int busy);
        @(negedge clk);
        cmd = c; addr = AW'(a); din = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        busy = 0;
        while (!ready) begin busy++; @(negedge clk); end
    endtask

    task automatic verify(input int a, output logic [7:0] v);
        @(negedge clk);
        cmd = 3'b010; addr = AW'(a);
        #1 v = dout;
    endtask

    task automatic erase(input int hold, output int busy);
        @(negedge clk);
        cmd = 3'b011; prog_n = 1'b0; busy = 0;
        repeat (hold) begin @(negedge clk); if (!ready) busy++; end
        prog_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(input string req, input logic [7:0] forced, input bit use_forced);
        logic [7:0] v;
        for (int a = 0; a < N; a++) begin
            verify(a, v);
            check(req, v, use_forced ? forced : model[a]);
        end
    endtask

    initial begin
        #(200000 * 5);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int busy;
        logic [7:0] v;
        logic [7:0] old;
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R3 ready high, R10 idle output, R1 blank array
        #1 check("R3 ready after reset", ready, 1);
        check("R10 idle dout", dout, 0);
        sweep("R1 blank after reset", 8'h00, 1'b0);

        // R6 signature bytes
        @(negedge clk); cmd = 3'b100; addr = 6'h30; #1 check("R6 sig 30h", dout, 8'h1E);
        @(negedge clk); addr = 6'h31; #1 check("R6 sig 31h", dout, 8'h52);
        @(negedge clk); addr = 6'h32; #1 check("R6 sig 32h", dout, 8'hFF);
        @(negedge clk); addr = 6'h05; #1 check("R6 sig other", dout, 8'h00);

        // R2/R3 write every address with two patterns, AND semantics
        for (int a = 0; a < N; a++) begin
            strobe(3'b001, a, pat_a(a), busy);
            check("R3 write busy length", busy, W);
            model[a] = model[a] & pat_a(a);
        end
        sweep("R2 first pattern", 8'h00, 1'b0);
        for (int a = 0; a < N; a++) begin
            strobe(3'b001, a, pat_b(a), busy);
            model[a] = model[a] & pat_b(a);
        end
        sweep("R2 AND of patterns", 8'h00, 1'b0);
        @(negedge clk); cmd = 3'b001; #1 check("R10 write-mode dout", dout, 0);

        // R4 data polling on address 5
        old = model[5];
        @(negedge clk);
        cmd = 3'b001; addr = 6'd5; din = 8'h7F; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; cmd = 3'b010;
        #1 check("R4 busy during poll", ready, 0);
        check("R4 polled bit7 inverted", dout[7], 1);
        while (!ready) @(negedge clk);
        model[5] = old & 8'h7F;
        #1 check("R4 true data after write", dout, model[5]);

        // R5 aborted erase leaves contents
        erase(5, busy);
        check("R5 abort busy length", busy, 5);
        sweep("R5 abort keeps array", 8'h00, 1'b0);

        // R5/R1 full erase
        erase(E + 2, busy);
        check("R5 erase busy length", busy, E);
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        sweep("R1 blank after erase", 8'h00, 1'b0);

        // R9 strobe during busy ignored, busy not extended
        @(negedge clk);
        cmd = 3'b001; addr = 6'd10; din = 8'h0F; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1; busy = 1;
        @(negedge clk); addr = 6'd11; din = 8'h00; prog_n = 1'b0; busy++;
        @(negedge clk); prog_n = 1'b1;
        while (!ready) begin busy++; @(negedge clk); end
        check("R9 busy not extended", busy, W);
        model[10] = 8'h0F;
        verify(11, v); check("R9 ignored write", v, 8'hFF);
        verify(10, v); check("R9 first write kept", v, 8'h0F);

        // R7/R8 lock bit 3 does not mask
        strobe(3'b111, 0, 8'h00, busy);
        check("R7 lock3 busy length", busy, W);
        verify(10, v); check("R8 lock3 leaves verify", v, 8'h0F);

        // R7/R8 lock bit 1 masks, survives writes and aborted erase
        strobe(3'b101, 0, 8'h00, busy);
        sweep("R8 lock1 masks verify", 8'hFF, 1'b1);
        strobe(3'b001, 20, 8'h33, busy);
        model[20] = 8'h33;
        erase(4, busy);
        verify(20, v); check("R7 lock1 sticky", v, 8'hFF);

        // R5 erase clears locks
        erase(E + 2, busy);
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        strobe(3'b001, 20, 8'h5A, busy);
        model[20] = 8'h5A;
        verify(20, v); check("R5 locks cleared by erase", v, 8'h5A);

        // R8 lock bit 2 masks
        strobe(3'b110, 0, 8'h00, busy);
        verify(20, v); check("R8 lock2 masks verify", v, 8'hFF);
        erase(E + 2, busy);
        verify(20, v); check("R1 blank after final erase", v, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule